// File: doc/BRIEF.md
# Transmit/Receive Converter Digital Interface

This block is the digital front of a converter pair that shares one clock: a 7-bit transmit path that feeds a DAC and a 5-bit receive path that carries ADC results. Two enable inputs pick one of three modes: transmit, receive or a low-power shutdown. Only the path that the mode selects moves. The other path keeps its last value.

Each path has two register stages. The first stage captures its input on the falling clock edge. The second stage moves that value to the output on the next rising edge. Receive codes are 5-bit two's complement and pass through unchanged. In shutdown the receive bus is held at all zeros.

A wake-up counter keeps both paths frozen for a set number of clock cycles after the block leaves shutdown. The default is 120 cycles, which is 2.4 µs at 50 MHz. An output flag shows when the active path is live. Switching straight between transmit and receive does not restart the counter.

Top module: `txrx_conv_if`

## Requirements
- R1: The mode is decoded from {en_rx, en_tx}. The value 01 selects transmit, 10 selects receive, and 00 or 11 selects shutdown.
- R2: A synchronous active-low reset sets dac_code and adc_dout to zero and clears path_ready. The block comes out of reset in the wake-up state.
- R3: path_ready first reads 1 after exactly WAKE_CYCLES rising edges with an active mode held without a break. Entering shutdown clears it in the same cycle and reloads the counter.
- R4: In transmit mode with path_ready high, dac_din is captured on the falling edge. It appears on dac_code at the next rising edge. A change to dac_din after that falling edge does not affect that update.
- R5: dac_code does not change while the block is in receive mode, in shutdown, or waiting for wake-up.
- R6: In receive mode with path_ready high, adc_sample is captured on the falling edge and appears unchanged on adc_dout at the next rising edge. Codes are two's complement with the sign in bit 4: 01111 is positive full scale, 10000 is negative full scale, and 00000 is mid-scale.
- R7: In transmit mode and during wake-up, the receive output register keeps its last value.
- R8: adc_dout reads all zeros during every cycle of shutdown.
- R9: A direct switch between transmit and receive leaves path_ready high and does not restart the counter.
- R10: A DAC code written before shutdown is still on dac_code through shutdown and the wake-up that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; both edges are used |
| rst_n | input | 1 | Synchronous reset, active low |
| en_rx | input | 1 | Receive enable |
| en_tx | input | 1 | Transmit enable |
| dac_din | input | 7 | Transmit data word |
| adc_sample | input | 5 | Quantized receive sample, two's complement |
| dac_code | output | 7 | Registered code to the DAC |
| adc_dout | output | 5 | Receive result, sign in bit 4 |
| path_ready | output | 1 | Active path live (wake-up over) |

## Verification
The bench sweeps every transmit word and every receive code. For each code it works out the signed value and checks the sign bit. A test that changes dac_din just after the falling edge catches a design that captures on the rising edge, because the later value would then appear. The counter is checked on the cycle before expiry and on the expiry cycle, so an off-by-one in the wake-up count fails. Other cases would catch a design that:
- restarts the counter on a direct mode switch;
- lets the idle path follow its input;
- leaves stale ADC data on the bus in shutdown, with either enable polarity;
- loses the DAC code across shutdown.

// File: rtl/conv_if_pkg.sv
// Shared types for the converter interface.
package conv_if_pkg;
    typedef enum logic [1:0] {
        MODE_SHDN = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RX   = 2'd2
    } conv_mode_e;
endpackage

// File: rtl/conv_mode_decode.sv
// Turns the two enable pins into an operating mode.
// Assumes the enables are already synchronous to clk. Equal levels of
// either polarity select shutdown.
module conv_mode_decode
    import conv_if_pkg::*;
(
    input  logic       en_rx,
    input  logic       en_tx,
    output conv_mode_e mode
);
    // Decode table: a single asserted enable picks its path.
    always_comb begin
        case ({en_rx, en_tx})
            2'b01:   mode = MODE_TX;
            2'b10:   mode = MODE_RX;
            default: mode = MODE_SHDN;
        endcase
    end
endmodule

// File: rtl/conv_wake_timer.sv
// Wake-up delay. The counter is loaded while the block is in shutdown
// and counts down in either active mode. ready is high once the count
// reaches zero and the mode is active.
// Assumes WAKE_CYCLES >= 1.
module conv_wake_timer
    import conv_if_pkg::*;
#(
    parameter int WAKE_CYCLES = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  conv_mode_e mode,
    output logic       ready
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          active;

    assign active = (mode != MODE_SHDN);

    // Reload in shutdown and count down while active. A switch between
    // transmit and receive leaves the count as it is.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= LOAD;
        else if (!active)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // The active path is live once the delay has run out.
    assign ready = active && (cnt_q == '0);

    AST_WAKE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHDN) |=> !ready); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD); // R3
    AST_READY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && active) |=> (ready || (mode == MODE_SHDN))); // R9
endmodule

// File: rtl/conv_dac_path.sv
// Transmit data path. The input stage captures on the falling edge. The
// code register takes that value on the next rising edge. Both stages
// move only while upd_en is high; otherwise they keep their values.
module conv_dac_path #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] code
);
    logic [W-1:0] in_q;
    logic [W-1:0] code_q;

    // Falling-edge input stage.
    always_ff @(negedge clk) begin
        if (!rst_n)
            in_q <= '0;
        else if (upd_en)
            in_q <= din;
    end

    // Rising-edge transfer to the code that drives the converter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (upd_en)
            code_q <= in_q;
    end

    assign code = code_q;

    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(code_q)); // R5
endmodule

// File: rtl/conv_adc_path.sv
// Receive data path. The sample stage captures on the falling edge and
// the output register updates on the rising edge. While force_low is
// high the bus reads zero; the register underneath keeps its value.
module conv_adc_path #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_en,
    input  logic         force_low,
    input  logic [W-1:0] sample,
    output logic [W-1:0] dout
);
    logic [W-1:0] samp_q;
    logic [W-1:0] hold_q;

    // Falling-edge sample stage.
    always_ff @(negedge clk) begin
        if (!rst_n)
            samp_q <= '0;
        else if (upd_en)
            samp_q <= sample;
    end

    // Rising-edge output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (upd_en)
            hold_q <= samp_q;
    end

    // Keep the bus low in shutdown.
    assign dout = force_low ? '0 : hold_q;

    AST_ADC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(hold_q)); // R7
endmodule

// File: rtl/txrx_conv_if.sv
// Top level of the converter digital interface: mode decode, wake-up
// timer, and the transmit and receive paths. Assumes one free-running
// clock. WAKE_CYCLES is the wake-up time in clock cycles.
module txrx_conv_if
    import conv_if_pkg::*;
#(
    parameter int DAC_W       = 7,
    parameter int ADC_W       = 5,
    parameter int WAKE_CYCLES = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_rx,
    input  logic             en_tx,
    input  logic [DAC_W-1:0] dac_din,
    input  logic [ADC_W-1:0] adc_sample,
    output logic [DAC_W-1:0] dac_code,
    output logic [ADC_W-1:0] adc_dout,
    output logic             path_ready
);
    conv_mode_e mode;
    logic       ready;
    logic       tx_upd;
    logic       rx_upd;

    conv_mode_decode i_decode (
        .en_rx (en_rx),
        .en_tx (en_tx),
        .mode  (mode)
    );

    conv_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) i_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .ready (ready)
    );

    // A path moves only in its own mode and after wake-up.
    assign tx_upd = ready && (mode == MODE_TX);
    assign rx_upd = ready && (mode == MODE_RX);

    conv_dac_path #(.W(DAC_W)) i_dac (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_en (tx_upd),
        .din    (dac_din),
        .code   (dac_code)
    );

    conv_adc_path #(.W(ADC_W)) i_adc (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (rx_upd),
        .force_low (mode == MODE_SHDN),
        .sample    (adc_sample),
        .dout      (adc_dout)
    );

    assign path_ready = ready;

    AST_SHDN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHDN) |-> (adc_dout == '0)); // R8
    AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_upd && rx_upd)); // R1
endmodule

// File: tb/test_txrx_conv_if.sv
`timescale 1ns/1ps
module test_txrx_conv_if;
    localparam int WAKE = 120;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en_rx, en_tx;
    logic [6:0] dac_din;
    logic [4:0] adc_sample;
    logic [6:0] dac_code;
    logic [4:0] adc_dout;
    logic       path_ready;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    txrx_conv_if #(.DAC_W(7), .ADC_W(5), .WAKE_CYCLES(WAKE)) i_txrx_conv_if (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_rx      (en_rx),
        .en_tx      (en_tx),
        .dac_din    (dac_din),
        .adc_sample (adc_sample),
        .dac_code   (dac_code),
        .adc_dout   (adc_dout),
        .path_ready (path_ready)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected wake-up: ready is low for WAKE-1 edges, then high.
    task automatic wake_up(input string req);
        for (int i = 1; i < WAKE; i++) begin
            tick();
            if (path_ready !== 1'b0) chk(req, path_ready, 0);
        end
        chk({req, " ready low before expiry"}, path_ready, 0);
        tick();
        chk({req, " ready at expiry"}, path_ready, 1);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; en_rx = 0; en_tx = 0; dac_din = '0; adc_sample = '0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R2: state after reset
        chk("R2 dac_code", dac_code, 0);
        chk("R2 adc_dout", adc_dout, 0);
        chk("R2 path_ready", path_ready, 0);

        // R1, R3: enter transmit; R5: data ignored during wake-up
        en_tx = 1; dac_din = 7'h55;
        wake_up("R3 tx");
        chk("R5 dac held in wake-up", dac_code, 0);

        // R4 sweep every transmit word; R7 receive output holds in transmit
        for (int v = 0; v < 128; v++) begin
            dac_din = 7'(v);
            adc_sample = 5'(v * 3);
            tick();
            chk("R4 dac sweep", dac_code, v);
            chk("R7 adc held in tx", adc_dout, 0);
        end

        // R4 falling-edge capture: a change after the falling edge waits a cycle
        dac_din = 7'h2A;
        @(negedge clk); #2 dac_din = 7'h15;
        @(posedge clk); #1;
        chk("R4 falling-edge capture", dac_code, 7'h2A);
        tick();
        chk("R4 late change next cycle", dac_code, 7'h15);

        // R9, R1: switch straight to receive
        en_tx = 0; en_rx = 1;
        #1 chk("R9 ready kept on tx->rx", path_ready, 1);
        for (int s = 0; s < 32; s++) begin
            int sv;
            adc_sample = 5'(s);
            dac_din = 7'(~s);
            tick();
            sv = (s >= 16) ? s - 32 : s;
            chk("R6 adc sweep", adc_dout, s);
            chk("R6 sign bit", int'(adc_dout[4]), (sv < 0) ? 1 : 0);
            chk("R5 dac held in rx", dac_code, 7'h15);
        end
        adc_sample = 5'b01111; tick();
        chk("R6 positive full scale", adc_dout, 5'b01111);
        adc_sample = 5'b10000; tick();
        chk("R6 negative full scale", adc_dout, 5'b10000);
        adc_sample = 5'b10110; tick();
        chk("R6 mid value", adc_dout, 5'b10110);

        // R9, R7: back to transmit, receive output holds
        en_rx = 0; en_tx = 1;
        #1 chk("R9 ready kept on rx->tx", path_ready, 1);
        adc_sample = 5'b00011;
        dac_din = 7'h33;
        tick();
        chk("R7 adc held after rx->tx", adc_dout, 5'b10110);
        chk("R1 tx updates dac", dac_code, 7'h33);

        // R8, R1, R3: shutdown with both enables high
        en_rx = 1; en_tx = 1;
        #1 chk("R8 adc low in shutdown 11", adc_dout, 0);
        chk("R3 ready drops in shutdown", path_ready, 0);
        for (int i = 0; i < 4; i++) begin
            dac_din = 7'(i + 9);
            adc_sample = 5'(i + 1);
            tick();
            chk("R10 dac held in shutdown", dac_code, 7'h33);
            chk("R8 adc low in shutdown 11", adc_dout, 0);
        end
        // R8: shutdown with both enables low
        en_rx = 0; en_tx = 0;
        tick();
        chk("R8 adc low in shutdown 00", adc_dout, 0);
        chk("R3 ready low in shutdown 00", path_ready, 0);

        // R3, R10, R7: wake into receive
        en_rx = 1;
        #1 chk("R3 ready low on wake", path_ready, 0);
        chk("R7 adc held in wake-up", adc_dout, 5'b10110);
        adc_sample = 5'b01001;
        wake_up("R3 rx");
        chk("R10 dac kept across shutdown", dac_code, 7'h33);
        chk("R7 adc still held at expiry", adc_dout, 5'b10110);
        tick();
        chk("R6 first sample after wake", adc_dout, 5'b01001);

        // R2: reset in mid-run clears state
        rst_n = 0;
        tick();
        rst_n = 1;
        chk("R2 dac after reset", dac_code, 0);
        chk("R2 adc after reset", adc_dout, 0);
        chk("R2 ready after reset", path_ready, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule